// File: doc/BRIEF.md
# Debug Scan-to-Bus Access Engine

This block sits behind a debug test port and turns words shifted in serially by an external debugger into read and write accesses on an internal system bus. The debugger selects an operation by scanning a 4-bit instruction, then scans a data-register word. Each data word is either an address with a read flag and a transfer size, or a write data word. While a word shifts in, the engine shifts out a snapshot of its status, taken at capture. The status holds three flags: an access is still pending (busy), the last access failed (error), and the chip is locked (protected).

The status snapshot decides what happens at update. When busy was reported, the new address or write data is dropped, and the debugger must repeat the scan. When error was reported, the new word is still taken. When protected was reported, no access is made. A cancel instruction aborts a pending access, for example when a bus slave never answers. The bus side is a single-outstanding master: request is held with address, size and data until acknowledge, and acknowledge comes with an error flag and read data.

The engine remembers whether the last accepted address was a read or a write. In read mode, a data scan only returns the last read result. In write mode, each accepted data word starts a write to the stored address.

Top module: `dbg_bus_access_engine`

## Requirements
- R1: After reset, busy and protected read 0, error reads 1, no bus request is active, and the selected instruction is idle.
- R2: Each capture of the instruction register or the data register loads busy into bit 0, error into bit 1 and protected into bit 2. These are the first three bits shifted out on `tdo`. Their values are those present at the capture cycle.
- R3: With instruction code 2 (address), a data scan is 38 bits. Bits 2:0 are ignored on input, bit 3 is the read flag, bits 5:4 are the size (0 byte, 1 halfword, 2 word, 3 reserved) and bits 37:6 are the address. When busy was clear at capture, address and size are stored and drive the bus. A set read flag starts a read.
- R4: If busy was reported during an address scan, the new address, size and read flag are discarded and the earlier ones stay in force.
- R5: With instruction code 3 (data) in write mode, bits 37:6 of a data scan are the write data. When busy was clear, the data is taken and a write starts to the stored address. When busy was reported, the data is discarded and the pending write keeps its data.
- R6: A data-instruction capture loads the last read result into bits 37:6. That value is valid only when busy was reported 0. In read mode, a data scan starts no access.
- R7: Error clears when an access starts and takes the bus error flag when the access completes. A reported error does not stop a new address or data word from being accepted and acted on.
- R8: When the lock input is high at capture, protected is reported and the following update starts no access.
- R9: A data-register update with instruction code 4 (cancel) while an access is pending drops the request at once, clears busy and sets error.
- R10: An access whose size is reserved, or whose address is not aligned to its size, issues no bus request and completes at once with error set and busy clear.
- R11: A bus request stays high, with address, size, direction and write data unchanged, until acknowledge or cancel. No second request is issued while one is outstanding.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| lock_i | input | 1 | Chip security lock; blocks accesses while high |
| ir_capture | input | 1 | Load status into the instruction shift register |
| ir_shift | input | 1 | Shift the instruction register one bit |
| ir_update | input | 1 | Select the shifted instruction |
| dr_capture | input | 1 | Load status and read data into the data shift register |
| dr_shift | input | 1 | Shift the data register one bit |
| dr_update | input | 1 | Act on the shifted data word |
| tdi | input | 1 | Serial data in, LSB first |
| tdo | output | 1 | Serial data out, LSB first |
| bus_req | output | 1 | Bus request, held until acknowledge |
| bus_we | output | 1 | 1 for write, 0 for read |
| bus_addr | output | WORD_W | Byte address |
| bus_size | output | 2 | 0 byte, 1 halfword, 2 word |
| bus_wdata | output | WORD_W | Write data |
| bus_ack | input | 1 | Access completed |
| bus_err | input | 1 | Completed access failed, valid with bus_ack |
| bus_rdata | input | WORD_W | Read data, valid with bus_ack |

## Verification
Some rules hold on every cycle and are checked there: the request is held stable until acknowledge or cancel, error clears whenever a request starts, a failed acknowledge leaves error set, a request never rises after a protected capture, cancel drops the request, and error reads 1 right after reset. Other behaviour only shows across a sequence of scans, so the bench scenarios must cover it. This includes dropping an address or data word because busy was reported, the proof that the old address stays in force, read data that is valid only once busy clears, misalignment that never reaches the bus, and a new word that is still taken after an error.

// File: rtl/dbgsab_pkg.sv
// Shared types for the debug scan-to-bus access engine.
// Assumes a 4-bit instruction register and a 3-bit status header.
package dbgsab_pkg;

    localparam int unsigned IR_W   = 4;
    localparam int unsigned STAT_W = 3;
    localparam int unsigned CTRL_W = 3;

    typedef enum logic [IR_W-1:0] {
        OP_IDLE   = 4'h0,
        OP_ADDR   = 4'h2,
        OP_DATA   = 4'h3,
        OP_CANCEL = 4'h4
    } dbg_op_e;

    typedef enum logic [1:0] {
        SZ_BYTE = 2'd0,
        SZ_HALF = 2'd1,
        SZ_WORD = 2'd2,
        SZ_RSVD = 2'd3
    } xfer_size_e;

    typedef struct packed {
        logic prot;
        logic err;
        logic busy;
    } scan_status_t;

    // True when the size is legal and the address low bits suit it.
    function automatic logic size_fits(input xfer_size_e sz, input logic [1:0] lsb);
        case (sz)
            SZ_BYTE: size_fits = 1'b1;
            SZ_HALF: size_fits = (lsb[0] == 1'b0);
            SZ_WORD: size_fits = (lsb == 2'b00);
            default: size_fits = 1'b0;
        endcase
    endfunction

endpackage

// File: rtl/dbgsab_scan_path.sv
// Instruction and data shift registers of the debug port.
// Captures the status header (and read data for the data instruction),
// shifts LSB first from tdi to tdo, and holds the selected instruction.
// Assumes capture, shift and update strobes are mutually exclusive.
module dbgsab_scan_path
    import dbgsab_pkg::*;
#(
    parameter int unsigned WORD_W = 32
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               ir_capture,
    input  logic               ir_shift,
    input  logic               ir_update,
    input  logic               dr_capture,
    input  logic               dr_shift,
    input  logic               tdi,
    input  scan_status_t       status,
    input  logic [WORD_W-1:0]  rd_word,
    output logic               tdo,
    output dbg_op_e            op,
    output scan_status_t       cap_stat,
    output logic [CTRL_W+WORD_W-1:0] payload
);

    localparam int unsigned PAY_W = CTRL_W + WORD_W;
    localparam int unsigned DR_W  = STAT_W + PAY_W;

    logic [IR_W-1:0] ir_sr;
    logic [DR_W-1:0] dr_sr;

    // Instruction shift register: capture status, shift, select on update.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ir_sr <= '0;
            op    <= OP_IDLE;
        end else begin
            if (ir_capture)
                ir_sr <= {{(IR_W-STAT_W){1'b0}}, status};
            else if (ir_shift)
                ir_sr <= {tdi, ir_sr[IR_W-1:1]};
            if (ir_update)
                op <= dbg_op_e'(ir_sr);
        end
    end

    // Data shift register: capture header and read data, then shift.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dr_sr    <= '0;
            cap_stat <= '0;
        end else if (dr_capture) begin
            dr_sr    <= {(op == OP_DATA) ? rd_word : {WORD_W{1'b0}},
                         {CTRL_W{1'b0}}, status};
            cap_stat <= status;
        end else if (dr_shift) begin
            dr_sr    <= {tdi, dr_sr[DR_W-1:1]};
        end
    end

    // Serial output follows whichever register is shifting.
    always_comb tdo = ir_shift ? ir_sr[0] : dr_sr[0];

    // Shifted-in word without the header positions.
    always_comb payload = dr_sr[DR_W-1:STAT_W];

endmodule

// File: rtl/dbgsab_access_ctrl.sv
// Access decision and bus master of the debug port.
// On each data-register update it uses the status captured for that scan
// to accept or drop the word, starts reads and writes, handles cancel,
// and tracks the error flag. Assumes the bus answers each request once.
module dbgsab_access_ctrl
    import dbgsab_pkg::*;
#(
    parameter int unsigned WORD_W = 32
) (
    input  logic               clk,
    input  logic               rst_n,
    input  dbg_op_e            op,
    input  scan_status_t       cap_stat,
    input  logic [CTRL_W+WORD_W-1:0] payload,
    input  logic               upd,
    input  logic               bus_ack,
    input  logic               bus_err,
    input  logic [WORD_W-1:0]  bus_rdata,
    output logic               bus_req,
    output logic               bus_we,
    output logic [WORD_W-1:0]  bus_addr,
    output logic [1:0]         bus_size,
    output logic [WORD_W-1:0]  bus_wdata,
    output logic               err_q,
    output logic [WORD_W-1:0]  rd_word,
    output logic               abort_fire
);

    logic              req_q, we_q, rd_mode_q;
    logic [WORD_W-1:0] addr_q, wdata_q;
    xfer_size_e        size_q;

    logic              accept, addr_evt, data_evt, done_evt;
    logic              pl_rd;
    xfer_size_e        pl_sz;
    logic [WORD_W-1:0] pl_word;
    logic              launch, launch_we, launch_ok;
    logic [WORD_W-1:0] launch_addr;
    xfer_size_e        launch_sz;

    // Split the shifted word into its fields.
    always_comb begin
        pl_rd   = payload[0];
        pl_sz   = xfer_size_e'(payload[2:1]);
        pl_word = payload[CTRL_W +: WORD_W];
    end

    // Decide whether this update is taken and what it starts.
    always_comb begin
        accept     = upd && !cap_stat.prot && !cap_stat.busy && !req_q;
        addr_evt   = accept && (op == OP_ADDR);
        data_evt   = accept && (op == OP_DATA) && !rd_mode_q;
        abort_fire = upd && (op == OP_CANCEL) && req_q;
        done_evt   = req_q && bus_ack && !abort_fire;
        launch     = (addr_evt && pl_rd) || data_evt;
        launch_we  = data_evt;
        launch_addr = addr_evt ? pl_word : addr_q;
        launch_sz   = addr_evt ? pl_sz   : size_q;
        launch_ok   = size_fits(launch_sz, launch_addr[1:0]);
    end

    // Stored address, size and direction mode.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_q    <= '0;
            size_q    <= SZ_WORD;
            rd_mode_q <= 1'b1;
        end else if (addr_evt) begin
            addr_q    <= pl_word;
            size_q    <= pl_sz;
            rd_mode_q <= pl_rd;
        end
    end

    // Write data register, loaded only when a write is taken.
    always_ff @(posedge clk) begin
        if (!rst_n)
            wdata_q <= '0;
        else if (data_evt)
            wdata_q <= pl_word;
    end

    // Request, direction and error flag of the single outstanding access.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            req_q <= 1'b0;
            we_q  <= 1'b0;
            err_q <= 1'b1;
        end else if (abort_fire) begin
            req_q <= 1'b0;
            err_q <= 1'b1;
        end else if (done_evt) begin
            req_q <= 1'b0;
            err_q <= bus_err;
        end else if (launch) begin
            req_q <= launch_ok;
            we_q  <= launch_we;
            err_q <= !launch_ok;
        end
    end

    // Last read result, kept until the next read completes.
    always_ff @(posedge clk) begin
        if (!rst_n)
            rd_word <= '0;
        else if (done_evt && !we_q)
            rd_word <= bus_rdata;
    end

    // Bus outputs come straight from the held registers.
    always_comb begin
        bus_req   = req_q;
        bus_we    = we_q;
        bus_addr  = addr_q;
        bus_size  = size_q;
        bus_wdata = wdata_q;
    end

endmodule

// File: rtl/dbg_bus_access_engine.sv
// Top of the debug scan-to-bus access engine.
// Joins the scan path and the access controller and builds the status
// header: busy is the pending request, protected is the lock input.
module dbg_bus_access_engine
    import dbgsab_pkg::*;
#(
    parameter int unsigned WORD_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              lock_i,
    input  logic              ir_capture,
    input  logic              ir_shift,
    input  logic              ir_update,
    input  logic              dr_capture,
    input  logic              dr_shift,
    input  logic              dr_update,
    input  logic              tdi,
    output logic              tdo,
    output logic              bus_req,
    output logic              bus_we,
    output logic [WORD_W-1:0] bus_addr,
    output logic [1:0]        bus_size,
    output logic [WORD_W-1:0] bus_wdata,
    input  logic              bus_ack,
    input  logic              bus_err,
    input  logic [WORD_W-1:0] bus_rdata
);

    scan_status_t              live_stat;
    scan_status_t              cap_stat;
    dbg_op_e                   op;
    logic [CTRL_W+WORD_W-1:0]  payload;
    logic [WORD_W-1:0]         rd_word;
    logic                      stat_err;
    logic                      abort_fire;
    logic                      cap_prot;

    // Live status header seen at every capture.
    always_comb begin
        live_stat.busy = bus_req;
        live_stat.err  = stat_err;
        live_stat.prot = lock_i;
        cap_prot       = cap_stat.prot;
    end

    dbgsab_scan_path #(.WORD_W(WORD_W)) i_scan (
        .clk        (clk),
        .rst_n      (rst_n),
        .ir_capture (ir_capture),
        .ir_shift   (ir_shift),
        .ir_update  (ir_update),
        .dr_capture (dr_capture),
        .dr_shift   (dr_shift),
        .tdi        (tdi),
        .status     (live_stat),
        .rd_word    (rd_word),
        .tdo        (tdo),
        .op         (op),
        .cap_stat   (cap_stat),
        .payload    (payload)
    );

    dbgsab_access_ctrl #(.WORD_W(WORD_W)) i_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .op         (op),
        .cap_stat   (cap_stat),
        .payload    (payload),
        .upd        (dr_update),
        .bus_ack    (bus_ack),
        .bus_err    (bus_err),
        .bus_rdata  (bus_rdata),
        .bus_req    (bus_req),
        .bus_we     (bus_we),
        .bus_addr   (bus_addr),
        .bus_size   (bus_size),
        .bus_wdata  (bus_wdata),
        .err_q      (stat_err),
        .rd_word    (rd_word),
        .abort_fire (abort_fire)
    );

endmodule

// File: rtl/dbgsab_checker.sv
// Protocol checks for the debug scan-to-bus access engine, bound to the top.
module dbgsab_checker #(
    parameter int unsigned WORD_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bus_req,
    input logic              bus_ack,
    input logic              bus_err,
    input logic              bus_we,
    input logic [WORD_W-1:0] bus_addr,
    input logic [1:0]        bus_size,
    input logic [WORD_W-1:0] bus_wdata,
    input logic              stat_err,
    input logic              abort_fire,
    input logic              cap_prot
);

    logic in_rst_q;

    // Remembers that the previous cycle was in reset.
    always_ff @(posedge clk) in_rst_q <= !rst_n;

    // R1: error reads 1 and no request in the first cycle after reset.
    always @(posedge clk) begin
        if (rst_n && in_rst_q)
            assert_err_after_reset_R1: assert (stat_err && !bus_req);
    end

    assert_req_held_R11: assert property (@(posedge clk) disable iff (!rst_n)
        bus_req && !bus_ack && !abort_fire |=> bus_req);

    assert_req_stable_R11: assert property (@(posedge clk) disable iff (!rst_n)
        bus_req && !bus_ack && !abort_fire |=>
            $stable(bus_addr) && $stable(bus_wdata) && $stable(bus_we) && $stable(bus_size));

    assert_err_clear_on_start_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(bus_req) |-> !stat_err);

    assert_bus_err_sets_R7: assert property (@(posedge clk) disable iff (!rst_n)
        bus_req && bus_ack && bus_err |=> stat_err && !bus_req);

    assert_lock_blocks_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(bus_req) |-> !$past(cap_prot));

    assert_cancel_drops_R9: assert property (@(posedge clk) disable iff (!rst_n)
        abort_fire |=> !bus_req && stat_err);

endmodule

bind dbg_bus_access_engine dbgsab_checker #(.WORD_W(WORD_W)) i_dbgsab_checker (
    .clk        (clk),
    .rst_n      (rst_n),
    .bus_req    (bus_req),
    .bus_ack    (bus_ack),
    .bus_err    (bus_err),
    .bus_we     (bus_we),
    .bus_addr   (bus_addr),
    .bus_size   (bus_size),
    .bus_wdata  (bus_wdata),
    .stat_err   (stat_err),
    .abort_fire (abort_fire),
    .cap_prot   (cap_prot)
);

// File: tb/test_dbg_bus_access_engine.sv
module test_dbg_bus_access_engine;

    localparam int W    = 32;
    localparam int DR_W = 38;
    localparam logic [3:0] C_IDLE = 4'h0, C_ADDR = 4'h2, C_DATA = 4'h3, C_CANCEL = 4'h4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic lock_i = 1'b0;
    logic ir_capture = 1'b0, ir_shift = 1'b0, ir_update = 1'b0;
    logic dr_capture = 1'b0, dr_shift = 1'b0, dr_update = 1'b0;
    logic tdi = 1'b0;
    logic tdo;
    logic bus_req, bus_we;
    logic [W-1:0] bus_addr, bus_wdata;
    logic [1:0] bus_size;
    logic bus_ack = 1'b0, bus_err = 1'b0;
    logic [W-1:0] bus_rdata = '0;

    int n_vec = 0, n_bad = 0;

    // responder controls and record
    bit hang = 1'b0, resp_err = 1'b0;
    int lat = 0, wcnt = 0, nreq = 0;
    bit prev_req = 1'b0;
    logic [W-1:0] last_wa = '0, last_wd = '0;
    logic last_we = 1'b0;
    logic [1:0] last_sz = '0;

    always #5 clk = ~clk;

    dbg_bus_access_engine #(.WORD_W(W)) i_dbg_bus_access_engine (
        .clk(clk), .rst_n(rst_n), .lock_i(lock_i),
        .ir_capture(ir_capture), .ir_shift(ir_shift), .ir_update(ir_update),
        .dr_capture(dr_capture), .dr_shift(dr_shift), .dr_update(dr_update),
        .tdi(tdi), .tdo(tdo),
        .bus_req(bus_req), .bus_we(bus_we), .bus_addr(bus_addr), .bus_size(bus_size),
        .bus_wdata(bus_wdata), .bus_ack(bus_ack), .bus_err(bus_err), .bus_rdata(bus_rdata)
    );

    function automatic logic [W-1:0] mem_fn(input logic [W-1:0] a);
        return {a[15:0], ~a[15:0]} ^ 32'h5A3C_0F96;
    endfunction

    function automatic logic [DR_W-1:0] addr_word(input logic rd, input logic [1:0] sz,
                                                  input logic [W-1:0] a);
        return {a, sz, rd, 3'b000};
    endfunction

    function automatic logic [DR_W-1:0] data_word(input logic [W-1:0] d);
        return {d, 6'b000000};
    endfunction

    function automatic logic [W-1:0] align(input logic [W-1:0] a, input logic [1:0] sz);
        return (sz == 2'd2) ? {a[W-1:2], 2'b00} : (sz == 2'd1) ? {a[W-1:1], 1'b0} : a;
    endfunction

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Bus slave model: acks after lat cycles unless hung.
    always @(negedge clk) begin
        if (!rst_n) begin
            bus_ack = 1'b0; wcnt = 0; prev_req = 1'b0;
        end else begin
            if (bus_req && !prev_req) nreq++;
            prev_req = bus_req;
            if (bus_ack) begin
                bus_ack = 1'b0;
            end else if (bus_req && !hang) begin
                if (wcnt >= lat) begin
                    bus_ack = 1'b1; bus_err = resp_err; bus_rdata = mem_fn(bus_addr);
                    last_wa = bus_addr; last_wd = bus_wdata; last_we = bus_we;
                    last_sz = bus_size; wcnt = 0;
                end else wcnt++;
            end
        end
    end

    task automatic scan_ir(input logic [3:0] code, output logic [3:0] o);
        @(negedge clk); #1 ir_capture = 1'b1;
        @(negedge clk); #1 ir_capture = 1'b0;
        for (int i = 0; i < 4; i++) begin
            ir_shift = 1'b1; tdi = code[i]; #1 o[i] = tdo;
            @(negedge clk); #1;
        end
        ir_shift = 1'b0; ir_update = 1'b1;
        @(negedge clk); #1 ir_update = 1'b0;
    endtask

    task automatic scan_dr(input logic [DR_W-1:0] din, output logic [DR_W-1:0] o);
        @(negedge clk); #1 dr_capture = 1'b1;
        @(negedge clk); #1 dr_capture = 1'b0;
        for (int i = 0; i < DR_W; i++) begin
            dr_shift = 1'b1; tdi = din[i]; #1 o[i] = tdo;
            @(negedge clk); #1;
        end
        dr_shift = 1'b0; dr_update = 1'b1;
        @(negedge clk); #1 dr_update = 1'b0;
    endtask

    task automatic settle();
        repeat (8) @(negedge clk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_vec++; n_bad++;
        $display("FAIL watchdog expired");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        logic [3:0] io;
        logic [DR_W-1:0] o;
        logic [W-1:0] a, d;
        logic [1:0] sz;
        logic rd;
        int base;
        void'($urandom(32'd20240611));

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 bus_req after reset", bus_req, 0);
        scan_ir(C_IDLE, io);
        chk("R1 reset status {prot,err,busy}", io[2:0], 3'b010);

        // R10: misaligned word read, reserved size, misaligned halfword write
        base = nreq;
        scan_ir(C_ADDR, io);
        scan_dr(addr_word(1'b1, 2'd2, 32'h0000_1002), o);
        chk("R2 DR header at capture", o[2:0], 3'b010);
        settle();
        chk("R10 misaligned word read no request", nreq - base, 0);
        scan_ir(C_ADDR, io);
        chk("R10 misaligned status", io[2:0], 3'b010);
        scan_dr(addr_word(1'b1, 2'd3, 32'h0000_2000), o);
        settle();
        chk("R10 reserved size no request", nreq - base, 0);
        scan_ir(C_ADDR, io);
        scan_dr(addr_word(1'b0, 2'd1, 32'h0000_3001), o);
        scan_ir(C_DATA, io);
        scan_dr(data_word(32'h1111_2222), o);
        settle();
        chk("R10 misaligned half write no request", nreq - base, 0);
        scan_ir(C_IDLE, io);
        chk("R10 error set busy clear", io[2:0], 3'b010);

        // R3: byte read at odd address
        lat = 1;
        scan_ir(C_ADDR, io);
        scan_dr(addr_word(1'b1, 2'd0, 32'h0040_0103), o);
        settle();
        chk("R3 byte read address", last_wa, 32'h0040_0103);
        chk("R3 byte read size", last_sz, 2'd0);
        chk("R3 read direction", last_we, 1'b0);
        scan_ir(C_DATA, io);
        scan_dr(data_word(32'h0), o);
        chk("R6 read status clean", o[2:0], 3'b000);
        chk("R6 read data", o[37:6], mem_fn(32'h0040_0103));

        // R4 + R9: busy address discard and cancel
        hang = 1'b1;
        base = nreq;
        scan_ir(C_ADDR, io);
        scan_dr(addr_word(1'b1, 2'd2, 32'h0000_A000), o);
        repeat (20) @(negedge clk);
        chk("R11 request held while unanswered", bus_req, 1'b1);
        scan_dr(addr_word(1'b0, 2'd2, 32'h0000_B000), o);
        chk("R4 busy reported on address scan", o[0], 1'b1);
        chk("R4 old address still driven", bus_addr, 32'h0000_A000);
        scan_ir(C_CANCEL, io);
        scan_dr('0, o);
        chk("R9 busy seen at cancel poll", o[0], 1'b1);
        @(negedge clk);
        chk("R9 request dropped", bus_req, 1'b0);
        scan_dr('0, o);
        chk("R9 status after cancel", o[2:0], 3'b010);
        hang = 1'b0;
        scan_ir(C_DATA, io);
        scan_dr(data_word(32'hDEAD_0001), o);
        settle();
        chk("R4 discarded write address never used", nreq - base, 1);

        // R5: busy write data discard
        scan_ir(C_ADDR, io);
        scan_dr(addr_word(1'b0, 2'd2, 32'h0000_C000), o);
        hang = 1'b1;
        base = nreq;
        scan_ir(C_DATA, io);
        scan_dr(data_word(32'hAAAA_0001), o);
        scan_dr(data_word(32'hBBBB_0002), o);
        chk("R5 busy reported on data scan", o[0], 1'b1);
        chk("R5 pending write data kept", bus_wdata, 32'hAAAA_0001);
        hang = 1'b0;
        settle();
        chk("R5 written data", last_wd, 32'hAAAA_0001);
        chk("R5 written address", last_wa, 32'h0000_C000);
        chk("R5 one write only", nreq - base, 1);

        // R7: error reported, new data still accepted
        resp_err = 1'b1;
        scan_dr(data_word(32'hCCCC_0003), o);
        settle();
        resp_err = 1'b0;
        scan_dr(data_word(32'hCCCC_0004), o);
        chk("R7 error reported on data scan", o[1], 1'b1);
        settle();
        chk("R7 data accepted after error", last_wd, 32'hCCCC_0004);
        scan_ir(C_ADDR, io);
        chk("R7 error cleared by good write", io[1], 1'b0);
        resp_err = 1'b1;
        scan_ir(C_DATA, io);
        scan_dr(data_word(32'hCCCC_0005), o);
        settle();
        resp_err = 1'b0;
        scan_ir(C_ADDR, io);
        scan_dr(addr_word(1'b1, 2'd2, 32'h0000_D004), o);
        chk("R7 error reported on address scan", o[1], 1'b1);
        settle();
        chk("R7 read started after error", {last_we, last_wa}, {1'b0, 32'h0000_D004});

        // R8: lock
        lock_i = 1'b1;
        base = nreq;
        scan_ir(C_ADDR, io);
        chk("R8 protected in IR header", io[2], 1'b1);
        scan_dr(addr_word(1'b1, 2'd2, 32'h0000_E000), o);
        chk("R8 protected in DR header", o[2], 1'b1);
        settle();
        chk("R8 no access while locked", nreq - base, 0);
        lock_i = 1'b0;

        // R6: read data invalid while busy
        hang = 1'b1;
        base = nreq;
        scan_dr(addr_word(1'b1, 2'd2, 32'h0000_F008), o);
        scan_ir(C_DATA, io);
        scan_dr(data_word(32'h0), o);
        chk("R6 busy on read poll", o[0], 1'b1);
        hang = 1'b0;
        settle();
        scan_dr(data_word(32'h0), o);
        chk("R6 read poll status", o[2:0], 3'b000);
        chk("R6 read data valid", o[37:6], mem_fn(32'h0000_F008));
        chk("R6 read-mode data scan starts nothing", nreq - base, 1);

        // random accesses
        for (int k = 0; k < 40; k++) begin
            rd = 1'($urandom % 2);
            sz = 2'($urandom % 3);
            a = align($urandom, sz);
            d = $urandom;
            lat = int'($urandom % 4);
            resp_err = (($urandom % 5) == 0);
            base = nreq;
            scan_ir(C_ADDR, io);
            scan_dr(addr_word(rd, sz, a), o);
            if (rd) begin
                settle();
                scan_ir(C_DATA, io);
                scan_dr(data_word(32'h0), o);
                chk("R3 random read status", o[2:0], {1'b0, resp_err, 1'b0});
                chk("R6 random read data", o[37:6], mem_fn(a));
            end else begin
                scan_ir(C_DATA, io);
                scan_dr(data_word(d), o);
                settle();
                chk("R5 random write data", last_wd, d);
                scan_ir(C_IDLE, io);
                chk("R7 random write status", io[2:0], {1'b0, resp_err, 1'b0});
            end
            chk("R3 random address", {last_we, last_sz, last_wa}, {~rd, sz, a});
            chk("R11 one request per access", nreq - base, 1);
        end
        resp_err = 1'b0;

        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

endmodule